// File: doc/BRIEF.md
# Receive Source Selector with Counter Test Pattern

This block chooses which stream feeds the frame capture stage of a wideband receiver. Three sources are available: the channelizer output, the raw ADC samples on a bypass path, and a generated counter pattern. The counter pattern puts a running sample index in the real part and a frame index in the imaginary part. It is used to check ordering, continuity and frame boundaries end to end.

Every path carries four complex samples per clock. Each sample is two signed 16-bit Q1.15 parts. A valid flag and a start-of-frame flag travel with the data. Channelizer samples arrive as signed 25-bit words with 23 fractional bits, and the block narrows them to Q1.15. A mode request takes effect only where the requested source starts a frame, so the capture stage never sees a frame made from two sources.

The stream follows the sample clock and has no back-pressure. Neither source can be stalled, so there is no ready signal. The capture stage must accept every cycle on which out_valid is high.

Top module: `rx_source_sel`

## Requirements
- R1: While rst_n is low, and after its release until the first valid input, out_valid, out_sof and out_data are all zero. The active source is the channelizer.
- R2: Outputs are registered with one cycle of latency. out_valid follows the valid of the active source. out_data is all zero when out_valid is low. out_sof is high only with out_valid. Lane k occupies out_data[32k+31:32k], with the imaginary part in the upper 16 bits and the real part in the lower 16 bits.
- R3: In counter mode (mode_sel = 2) the pattern is paced by raw_valid. Lane k carries real = idx + k. idx steps by 4 on every paced cycle and wraps from 508 to 0. The pattern's start-of-frame is the paced cycle on which idx is 0.
- R4: In counter mode every lane's imaginary part is the frame index. The frame index increments when idx wraps and rolls over modulo 2^16.
- R5: A high sw_trigger clears both counters at that clock edge. The next paced cycle presents idx 0, frame 0, and start-of-frame.
- R6: In channelizer mode (mode_sel = 0) each 25-bit part (lane k real in chan_data[50k+24:50k], imag in chan_data[50k+49:50k+25]) is converted to Q1.15. The conversion drops 8 fractional bits and rounds to nearest, with ties going toward positive infinity.
- R7: Channelizer parts outside the Q1.15 range after rounding saturate to 32767 or -32768.
- R8: In bypass mode (mode_sel = 1) raw_data appears on out_data unchanged, with no filtering or transform.
- R9: A new mode_sel becomes active only on a cycle where the requested source shows valid and start-of-frame together. That cycle's output already comes from the new source. Until then the previous source continues.
- R10: The request code 3 is ignored, and the active source does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Requested source: 0 channelizer, 1 bypass, 2 counter |
| sw_trigger | input | 1 | Software capture trigger; clears the counter pattern |
| chan_valid | input | 1 | Channelizer data valid |
| chan_sof | input | 1 | Channelizer start of frame |
| chan_data | input | 200 | Four complex channelizer samples, 25 bits per part |
| raw_valid | input | 1 | Bypass data valid; also paces the counter pattern |
| raw_sof | input | 1 | Bypass start of frame |
| raw_data | input | 128 | Four complex raw samples in Q1.15 |
| out_valid | output | 1 | Output data valid |
| out_sof | output | 1 | Output start of frame |
| out_data | output | 128 | Four complex Q1.15 samples to capture |

## Verification
Every result appears one clock edge after the inputs that cause it. This covers requantized channelizer lanes, bypass words, counter lanes and the source switch. The bench drives inputs just after a rising edge and samples the outputs just after the next rising edge.

A trigger clears the counters at the edge on which it is high. Its effect therefore shows on the output one edge after the following paced cycle. The bench checks both the last pre-clear word and the first cleared word.

A wrap is due on the 128th paced cycle after idx 0. The bench counts paced cycles to reach that point before it checks the frame index and start-of-frame.

// File: rtl/rx_src_pkg.sv
package rx_src_pkg;
  typedef enum logic [1:0] {
    SRC_CHAN = 2'd0,
    SRC_RAW  = 2'd1,
    SRC_CNT  = 2'd2,
    SRC_RSVD = 2'd3
  } src_mode_e;
endpackage

// File: rtl/rx_lane_requant.sv
module rx_lane_requant #(
  parameter int IN_W    = 25,
  parameter int IN_FRAC = 23,
  parameter int OUT_W   = 16
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int DROP  = IN_FRAC - (OUT_W - 1);
  localparam int EXT_W = IN_W + 1;
  localparam int SH_W  = EXT_W - DROP;
  localparam logic [EXT_W-1:0] HALF = EXT_W'(1) << (DROP - 1);
  localparam logic signed [SH_W-1:0] MAXV = SH_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [SH_W-1:0] MINV = SH_W'(-(2 ** (OUT_W - 1)));

  logic [EXT_W-1:0]       biased;
  logic signed [SH_W-1:0] shifted;

  // sign-extend one bit so the rounding offset cannot overflow
  assign biased  = {din[IN_W-1], din} + HALF;
  assign shifted = biased[EXT_W-1:DROP];

  always_comb begin
    if (shifted > MAXV)      dout = MAXV[OUT_W-1:0];
    else if (shifted < MINV) dout = MINV[OUT_W-1:0];
    else                     dout = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/rx_test_pattern.sv
module rx_test_pattern #(
  parameter int LANES     = 4,
  parameter int FRAME_LEN = 512,
  parameter int SW        = 16,
  parameter int FRM_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   clear,
  output logic                   pat_valid,
  output logic                   pat_sof,
  output logic [LANES*2*SW-1:0]  pat_data
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - LANES);
  localparam logic [IDX_W-1:0] STEP = IDX_W'(LANES);

  logic [IDX_W-1:0] idx;
  logic [FRM_W-1:0] frm;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      idx <= '0;
      frm <= '0;
    end else if (tick) begin
      if (idx == LAST) begin
        idx <= '0;
        frm <= frm + 1'b1;
      end else begin
        idx <= idx + STEP;
      end
    end
  end

  assign pat_valid = tick;
  assign pat_sof   = tick && (idx == '0);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign pat_data[k*2*SW +: SW]    = SW'(idx) + SW'(k);
    assign pat_data[k*2*SW+SW +: SW] = SW'(frm);
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && idx != LAST) |=> idx == $past(idx) + STEP);
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && idx == LAST) |=> (idx == '0 && frm == $past(frm) + 1'b1));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (idx == '0 && frm == '0));
endmodule

// File: rtl/rx_src_arbiter.sv
module rx_src_arbiter
  import rx_src_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  src_mode_e req_mode,
  input  logic [3:0] src_valid,
  input  logic [3:0] src_sof,
  output src_mode_e eff_mode,
  output src_mode_e act_mode
);
  logic switch_now;

  assign switch_now = (req_mode != SRC_RSVD) && (req_mode != act_mode) &&
                      src_valid[req_mode] && src_sof[req_mode];
  assign eff_mode   = switch_now ? req_mode : act_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) act_mode <= SRC_CHAN;
    else        act_mode <= eff_mode;
  end

  p_no_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act_mode != SRC_RSVD);
endmodule

// File: rtl/rx_source_sel.sv
module rx_source_sel
  import rx_src_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int CHN_W     = 25,
  parameter int CHN_FRAC  = 23,
  parameter int SW        = 16,
  parameter int FRAME_LEN = 512,
  parameter int FRM_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_sel,
  input  logic                     sw_trigger,
  input  logic                     chan_valid,
  input  logic                     chan_sof,
  input  logic [LANES*2*CHN_W-1:0] chan_data,
  input  logic                     raw_valid,
  input  logic                     raw_sof,
  input  logic [LANES*2*SW-1:0]    raw_data,
  output logic                     out_valid,
  output logic                     out_sof,
  output logic [LANES*2*SW-1:0]    out_data
);
  localparam int OW = LANES * 2 * SW;
  localparam int PARTS = LANES * 2;

  logic [OW-1:0] chan_q15;
  logic          cnt_valid, cnt_sof;
  logic [OW-1:0] cnt_data;
  src_mode_e     eff_mode, act_mode;
  logic          sel_v, sel_s;
  logic [OW-1:0] sel_d;

  for (genvar p = 0; p < PARTS; p++) begin : g_part
    rx_lane_requant #(.IN_W(CHN_W), .IN_FRAC(CHN_FRAC), .OUT_W(SW)) u_rq (
      .din  (chan_data[p*CHN_W +: CHN_W]),
      .dout (chan_q15[p*SW +: SW])
    );
  end

  rx_test_pattern #(
    .LANES(LANES), .FRAME_LEN(FRAME_LEN), .SW(SW), .FRM_W(FRM_W)
  ) u_pat (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (raw_valid),
    .clear     (sw_trigger),
    .pat_valid (cnt_valid),
    .pat_sof   (cnt_sof),
    .pat_data  (cnt_data)
  );

  rx_src_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_mode  (src_mode_e'(mode_sel)),
    .src_valid ({1'b0, cnt_valid, raw_valid, chan_valid}),
    .src_sof   ({1'b0, cnt_sof, raw_sof, chan_sof}),
    .eff_mode  (eff_mode),
    .act_mode  (act_mode)
  );

  always_comb begin
    case (eff_mode)
      SRC_RAW: begin sel_v = raw_valid;  sel_s = raw_sof;  sel_d = raw_data; end
      SRC_CNT: begin sel_v = cnt_valid;  sel_s = cnt_sof;  sel_d = cnt_data; end
      SRC_CHAN: begin sel_v = chan_valid; sel_s = chan_sof; sel_d = chan_q15; end
      default: begin sel_v = 1'b0;       sel_s = 1'b0;     sel_d = '0;       end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= sel_v;
      out_sof   <= sel_v && sel_s;
      out_data  <= sel_v ? sel_d : '0;
    end
  end

  p_sof_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);
  p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_data[CHN_W-1] |-> !chan_q15[SW-1]);
  p_switch_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode != $past(act_mode)) |-> out_sof);
endmodule

// File: tb/rx_source_sel_tb.sv
module rx_source_sel_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode_sel;
  logic         sw_trigger;
  logic         chan_valid, chan_sof;
  logic [199:0] chan_data;
  logic         raw_valid, raw_sof;
  logic [127:0] raw_data;
  logic         out_valid, out_sof;
  logic [127:0] out_data;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  rx_source_sel u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_trigger(sw_trigger),
    .chan_valid(chan_valid), .chan_sof(chan_sof), .chan_data(chan_data),
    .raw_valid(raw_valid), .raw_sof(raw_sof), .raw_data(raw_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
  );

  // {input 25 bits, expected 16 bits, saturating case}
  localparam logic [41:0] VEC [0:13] = '{
    {25'sd0,        16'sd0,      1'b0},
    {25'sd127,      16'sd0,      1'b0},
    {25'sd128,      16'sd1,      1'b0},
    {25'sd383,      16'sd1,      1'b0},
    {25'sd384,      16'sd2,      1'b0},
    {-25'sd128,     16'sd0,      1'b0},
    {-25'sd129,     -16'sd1,     1'b0},
    {-25'sd385,     -16'sd2,     1'b0},
    {25'sd8388479,  16'sd32767,  1'b0},
    {-25'sd8388608, -16'sd32768, 1'b0},
    {25'sd8388480,  16'sd32767,  1'b1},
    {25'sd16777215, 16'sd32767,  1'b1},
    {-25'sd16777216,-16'sd32768, 1'b1},
    {-25'sd8388737, -16'sd32768, 1'b1}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] cnt_word(input int idx, input int frm);
    logic [127:0] w;
    for (int k = 0; k < 4; k++) w[k*32 +: 32] = {16'(frm), 16'(idx + k)};
    return w;
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] rawA, rawB, chx;
    rst_n = 1'b0; mode_sel = 2'd0; sw_trigger = 1'b0;
    chan_valid = 1'b0; chan_sof = 1'b0; chan_data = '0;
    raw_valid = 1'b0; raw_sof = 1'b0; raw_data = '0;
    tick(); tick(); tick();
    chk("R1 valid", 128'(out_valid), 128'd0);
    chk("R1 sof", 128'(out_sof), 128'd0);
    chk("R1 data", out_data, 128'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", {126'd0, out_valid, out_sof}, 128'd0);

    // requantization table (R6 rounding, R7 saturation)
    for (int i = 0; i < 14; i++) begin
      chan_valid = 1'b1;
      chan_sof   = (i == 0);
      chan_data  = {8{VEC[i][41:17]}};
      tick();
      chk(VEC[i][0] ? "R7 saturate" : "R6 round", out_data, {8{VEC[i][16:1]}});
      chk("R2 valid", 128'(out_valid), 128'd1);
    end

    chan_valid = 1'b0;
    tick();
    chk("R2 idle zero", {out_data[126:0], out_valid}, 128'd0);

    // mode switch to bypass waits for raw start-of-frame (R9)
    rawA = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    rawB = 128'h8000_7fff_0001_ffff_1234_5678_9abc_def0;
    mode_sel = 2'd1; raw_valid = 1'b1; raw_sof = 1'b0; raw_data = rawA;
    chan_valid = 1'b1; chan_sof = 1'b0; chan_data = {8{25'sd256}};
    tick();
    chx = {8{16'sd1}};
    chk("R9 hold old source", out_data, chx);
    raw_sof = 1'b1;
    tick();
    chk("R9 switch at sof", out_data, rawA);
    chk("R9 sof out", 128'(out_sof), 128'd1);
    raw_sof = 1'b0; raw_data = rawB;
    tick();
    chk("R8 bypass passthrough", out_data, rawB);

    // counter mode (R3, R4, R5)
    raw_valid = 1'b0; sw_trigger = 1'b1;
    tick();
    sw_trigger = 1'b0; mode_sel = 2'd2; raw_valid = 1'b1;
    tick();
    chk("R5 cleared pattern", out_data, cnt_word(0, 0));
    chk("R3 sof at idx0", 128'(out_sof), 128'd1);
    for (int i = 1; i <= 130; i++) begin
      tick();
      if (i == 1) begin
        chk("R3 step by 4", out_data, cnt_word(4, 0));
        chk("R3 no sof mid", 128'(out_sof), 128'd0);
      end
      if (i == 127) chk("R3 last slot", out_data, cnt_word(508, 0));
      if (i == 128) begin
        chk("R4 frame increment", out_data, cnt_word(0, 1));
        chk("R4 sof at wrap", 128'(out_sof), 128'd1);
      end
    end
    sw_trigger = 1'b1;
    tick();
    chk("R5 word before clear", out_data, cnt_word(12, 1));
    sw_trigger = 1'b0;
    tick();
    chk("R5 restart", out_data, cnt_word(0, 0));
    chk("R5 sof", 128'(out_sof), 128'd1);

    // reserved code ignored even with bypass sof (R10)
    mode_sel = 2'd3; raw_sof = 1'b1; raw_data = rawA;
    tick();
    chk("R10 reserved ignored", out_data, cnt_word(4, 0));
    raw_sof = 1'b0;

    // request channelizer without sof: stays counter (R9)
    mode_sel = 2'd0; chan_valid = 1'b1; chan_sof = 1'b0;
    tick();
    chk("R9 wait for chan sof", out_data, cnt_word(8, 0));
    chan_sof = 1'b1;
    tick();
    chk("R9 switch to chan", out_data, chx);
    chk("R9 chan sof", 128'(out_sof), 128'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule